// File: doc/BRIEF.md
# Word-Serial CORDIC Rotator

This block rotates a two-dimensional vector by a given angle using the CORDIC shift-and-add method, folded onto a single datapath. Three branch registers hold the x coordinate, the y coordinate and the remaining angle. Each clock performs one micro-rotation. The x and y branches each add or subtract a right-shifted copy of the other branch. The angle branch adds or subtracts a hardwired arctangent constant. The sign of the angle register chooses the direction. The shift distance and the constant both follow an iteration counter.

A pulse on `start` while the block is idle captures the input vector and angle. Iteration 0 runs in that same cycle, and the block then runs the remaining `N-1` iterations on its own. When the last iteration lands, `done` pulses for one cycle. `x_out`, `y_out` and `z_out` then hold the result until the next accepted start, so a new operand can be taken once every `N` clocks.

The outputs keep the CORDIC gain K = prod over i<N of sqrt(1+2^-2i), which is about 1.647 for large `N`. A caller that wants an unscaled result multiplies the input magnitude by about 0.6073 beforehand.

Top module: `rot_cordic`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `x_out`, `y_out` and `z_out` are 0.
- R2: A `start` seen high at a clock edge while `busy` is 0 is accepted, and `busy` reads 1 after that edge.
- R3: `done` goes high exactly `N` clock edges after the accepted start edge, counting that edge as the first. It stays high for a single cycle, and `busy` is 0 while it is high.
- R4: A `start` raised while `busy` is 1 is ignored. The running computation keeps its timing and its operands.
- R5: While idle and without `start`, `x_out`, `y_out` and `z_out` keep their values, whatever `x_in`, `y_in` and `z_in` do.
- R6: The angle input is a signed `AW`-bit word in which 2^(AW-1) stands for pi/2, so it spans -pi/2 up to just below +pi/2. The final `x_out` and `y_out` equal K·(x·cos θ − y·sin θ) and K·(x·sin θ + y·cos θ) within 12 LSB, with positive θ turning counter-clockwise.
- R7: The final `z_out` is the residual angle and lies within 20 LSB of zero.
- R8: A `start` given in the cycle where `done` is high is accepted. That operand completes after another `N` edges, which sustains one result per `N` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to load a new operand |
| x_in | input | W | Initial x, two's complement |
| y_in | input | W | Initial y, two's complement |
| z_in | input | AW | Rotation angle, 2^(AW-1) = pi/2 |
| busy | output | 1 | Computation in flight |
| done | output | 1 | One-cycle pulse when the result is ready |
| x_out | output | W | Rotated x, scaled by K |
| y_out | output | W | Rotated y, scaled by K |
| z_out | output | AW | Residual angle |

## Verification
Rotations are tried with a vector on the positive x axis at zero, positive and negative angles. These separate a correct direction choice from a mirrored one, and show the zero-angle gain on its own. Vectors with both coordinates nonzero and in other quadrants, at both ends of the angle range, confirm the cross-coupling signs of the x and y branches and the convergence at ±pi/2. A start given mid-computation, a start given in the done cycle, and idle cycles with changing inputs separate correct operand capture from premature reloading or leakage of the inputs into the outputs.

// File: rtl/rot_cordic.sv
module rot_cordic #(
  parameter int W  = 16,
  parameter int AW = 16,
  parameter int N  = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic signed [W-1:0]  x_in,
  input  logic signed [W-1:0]  y_in,
  input  logic signed [AW-1:0] z_in,
  output logic                 busy,
  output logic                 done,
  output logic signed [W-1:0]  x_out,
  output logic signed [W-1:0]  y_out,
  output logic signed [AW-1:0] z_out
);
  localparam int CW = (N > 2) ? $clog2(N) : 1;

  // arctan(2^-i) with pi/2 = 2^31, rounded to AW bits
  function automatic logic [AW-1:0] atan_word(input int i);
    logic [31:0] b;
    logic [32:0] t;
    case (i)
      0:  b = 32'd1073741824;
      1:  b = 32'd633866812;
      2:  b = 32'd334917814;
      3:  b = 32'd170009512;
      4:  b = 32'd85334662;
      5:  b = 32'd42708930;
      6:  b = 32'd21359676;
      7:  b = 32'd10680490;
      8:  b = 32'd5340326;
      9:  b = 32'd2670174;
      10: b = 32'd1335088;
      11: b = 32'd667544;
      12: b = 32'd333772;
      13: b = 32'd166886;
      14: b = 32'd83443;
      15: b = 32'd41722;
      default: b = 32'd1367130551 >> i;
    endcase
    t = {1'b0, b} + (33'd1 << (31 - AW));
    return t[32-AW +: AW];
  endfunction

  logic signed [W-1:0]  xr, yr;
  logic signed [AW-1:0] zr;
  logic [CW-1:0]        cnt;
  logic                 busy_q, done_q;

  wire load = start & ~busy_q;

  wire signed [W-1:0]  xs   = load ? x_in : xr;
  wire signed [W-1:0]  ys   = load ? y_in : yr;
  wire signed [AW-1:0] zs   = load ? z_in : zr;
  wire [CW-1:0]        step = load ? '0 : cnt;
  wire                 neg  = zs[AW-1];

  wire signed [W-1:0]  xsh = xs >>> step;
  wire signed [W-1:0]  ysh = ys >>> step;
  wire signed [AW-1:0] ang = atan_word(int'(step));

  wire signed [W-1:0]  xn = neg ? xs + ysh : xs - ysh;
  wire signed [W-1:0]  yn = neg ? ys - xsh : ys + xsh;
  wire signed [AW-1:0] zn = neg ? zs + ang : zs - ang;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xr     <= '0;
      yr     <= '0;
      zr     <= '0;
      cnt    <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load || busy_q) begin
        xr <= xn;
        yr <= yn;
        zr <= zn;
      end
      if (load) begin
        if (N > 1) begin
          busy_q <= 1'b1;
          cnt    <= CW'(1);
        end else begin
          done_q <= 1'b1;
        end
      end else if (busy_q) begin
        if (cnt == CW'(N - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign x_out = xr;
  assign y_out = yr;
  assign z_out = zr;
endmodule

// File: rtl/rot_cordic_chk.sv
module rot_cordic_chk #(
  parameter int W  = 16,
  parameter int AW = 16,
  parameter int N  = 14
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic signed [W-1:0]  x_out,
  input logic signed [W-1:0]  y_out,
  input logic signed [AW-1:0] z_out
);
  logic [31:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lat <= '0;
    else if (start && !busy) lat <= 32'd1;
    else if (busy)           lat <= lat + 32'd1;
  end

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R3
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) done |-> (lat == 32'(N))); // R3
  AST_BUSY_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (busy && lat != 32'(N - 1)) |=> busy); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(x_out) && $stable(y_out) && $stable(z_out))); // R5
endmodule

bind rot_cordic rot_cordic_chk #(.W(W), .AW(AW), .N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .x_out(x_out), .y_out(y_out), .z_out(z_out)
);

// File: tb/rot_cordic_tb.sv
module rot_cordic_tb;
  localparam int  W  = 16;
  localparam int  AW = 16;
  localparam int  N  = 14;
  localparam time CLK_PERIOD = 10;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic signed [W-1:0]  x_in = '0, y_in = '0;
  logic signed [AW-1:0] z_in = '0;
  logic busy, done;
  logic signed [W-1:0]  x_out, y_out;
  logic signed [AW-1:0] z_out;

  int  n_pass = 0, n_tot = 0;
  real gain;

  rot_cordic #(.W(W), .AW(AW), .N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_in(y_in), .z_in(z_in),
    .busy(busy), .done(done), .x_out(x_out), .y_out(y_out), .z_out(z_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input real act, input real exp);
    n_tot++;
    if (ok) n_pass++;
    else $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
  endtask

  task automatic launch(input int x, input int y, input int z);
    @(negedge clk);
    start = 1'b1; x_in = W'(x); y_in = W'(y); z_in = AW'(z);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int c0, output int cyc);
    cyc = c0;
    while (!done && cyc < N + 6) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic check_vec(input int x, input int y, input int z, input string req);
    real th, ex, ey, dx, dy, dz;
    th = real'(z) * (PI / 2.0) / (2.0 ** (AW - 1));
    ex = gain * (real'(x) * $cos(th) - real'(y) * $sin(th));
    ey = gain * (real'(x) * $sin(th) + real'(y) * $cos(th));
    dx = real'(x_out) - ex; dy = real'(y_out) - ey; dz = real'(z_out);
    chk(dx <= 12.0 && dx >= -12.0, req, "x_out", real'(x_out), ex);
    chk(dy <= 12.0 && dy >= -12.0, req, "y_out", real'(y_out), ey);
    chk(dz <= 20.0 && dz >= -20.0, "R7", "z residual", dz, 0.0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !done, "R1", "busy/done after reset", real'({busy, done}), 0.0);
    chk(x_out == 0 && y_out == 0 && z_out == 0, "R1", "outputs after reset", real'(x_out), 0.0);
  endtask

  task automatic t_rot(input int x, input int y, input int z);
    int cyc;
    launch(x, y, z);
    chk(busy, "R2", "busy after start", real'(busy), 1.0);
    wait_done(1, cyc);
    chk(cyc == N, "R3", "done latency", real'(cyc), real'(N));
    check_vec(x, y, z, "R6");
    @(negedge clk);
    chk(!done, "R3", "done one cycle", real'(done), 0.0);
  endtask

  task automatic t_ignore();
    int cyc;
    launch(6000, 1000, 9000);
    repeat (3) @(negedge clk);
    start = 1'b1; x_in = -W'(3000); y_in = W'(4000); z_in = -AW'(20000);
    @(negedge clk);
    start = 1'b0;
    wait_done(5, cyc);
    chk(cyc == N, "R4", "latency with start while busy", real'(cyc), real'(N));
    check_vec(6000, 1000, 9000, "R4");
  endtask

  task automatic t_b2b();
    int cyc;
    launch(5500, -500, -7000);
    wait_done(1, cyc);
    check_vec(5500, -500, -7000, "R8");
    start = 1'b1; x_in = W'(-2000); y_in = W'(-5000); z_in = AW'(25000);
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R8", "start in done cycle accepted", real'(busy), 1.0);
    wait_done(1, cyc);
    chk(cyc == N, "R8", "second latency", real'(cyc), real'(N));
    check_vec(-2000, -5000, 25000, "R8");
  endtask

  task automatic t_hold();
    int cyc;
    logic signed [W-1:0] hx, hy;
    logic signed [AW-1:0] hz;
    launch(4500, 2500, -12000);
    wait_done(1, cyc);
    hx = x_out; hy = y_out; hz = z_out;
    for (int k = 0; k < 6; k++) begin
      x_in = W'(100 * k); y_in = -W'(300 * k); z_in = AW'(5000 * k);
      @(negedge clk);
    end
    chk(x_out == hx && y_out == hy && z_out == hz, "R5", "outputs held while idle", real'(x_out), real'(hx));
    chk(!busy && !done, "R5", "stays idle", real'({busy, done}), 0.0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    n_tot++;
    $display("FAIL watchdog: actual %0d expected fewer cycles", cyc);
    $display("%0d/%0d checks passed", n_pass, n_tot);
    $finish;
  end

  initial begin
    gain = 1.0;
    for (int i = 0; i < N; i++) gain = gain * $sqrt(1.0 + 2.0 ** (-2 * i));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rot(6000, 0, 0);
    t_rot(6000, 0, 5461);
    t_rot(6000, 0, -8192);
    t_rot(5000, 3000, 16000);
    t_rot(4000, -5000, -32768);
    t_rot(-6000, 2000, 32767);
    t_rot(0, 6000, 12000);
    t_ignore();
    t_b2b();
    t_hold();
    $display("%0d/%0d checks passed", n_pass, n_tot);
    $finish;
  end
endmodule